// File: doc/BRIEF.md
# Latchable Channel-Select Decoder

This block is the control logic of a bus-attached analog multiplexer. A processor places a binary channel number and an enable bit on the inputs. While the write strobe is low, the block follows them. When the strobe rises, the last channel number and enable are kept. The processor can then release the bus, and the chosen switch stays on. An active-low reset clears the kept state and opens every switch.

All inputs are sampled on the rising edge of a system clock. The held state lives in a register. The one-hot switch vector is decoded from that register, so a change at the inputs shows at the outputs one clock later. One parameter sets the address width: 3 bits give an 8-way selector, and 2 bits give a 4-way selector for the dual variant. Several blocks can be combined into wider multiplexers by driving enable low on all but one of them.

Top module: `chan_hold_sel`

## Requirements
- R1: After a sampled reset the held enable is 0. All switch outputs stay 0 until a cycle with write low, reset high and enable high is sampled. A held cycle with write high does not turn any output on.
- R2: In a cycle where reset is high, write is low and enable is high, the sampled address A sets output bit A one clock later and clears every other bit. Address 0 drives bit 0, which is channel 1. The top address drives the top bit.
- R3: In a cycle where reset is high, write is low and enable is low, all outputs are 0 one clock later, whatever the address.
- R4: In a cycle where reset is high and write is high, the held address and enable do not change. The outputs one clock later equal the outputs before that cycle, whatever the address and enable inputs are.
- R5: In a cycle where reset is low, all outputs are 0 one clock later and the held state is cleared. This holds even when write is high.
- R6: At most one output bit is 1 at any time.
- R7: With ADDR_W = 2 there are 4 outputs and a 2-bit address. The latch, enable and reset behaviour is the same as in the 8-output build.
- R8: After a hold, a cycle with write low again makes the outputs follow the current address and enable one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low clear of the held state and outputs |
| wr | input | 1 | Write strobe: 0 = follow the inputs, 1 = hold |
| addr | input | ADDR_W | Binary channel number; 0 selects channel 1 |
| en | input | 1 | Channel enable; 0 opens all switches |
| sw_on | output | 2**ADDR_W | One-hot switch controls; bit k is channel k+1 |

## Verification
The bench builds two copies from the same stimulus. One uses ADDR_W = 3 and drives 8 outputs. The other uses ADDR_W = 2 and drives 4 outputs, and it receives only the lower two address bits. The 8-output copy lets the bench walk every channel and check the top-bit boundary. The 4-output copy shows that the same hold, enable and reset sequences give the same results at the narrower width. The narrow copy also wraps its address space while the wide copy is still counting, so one run checks both decode widths against one model.

// File: rtl/chan_hold_pkg.sv
package chan_hold_pkg;
   localparam int unsigned MIN_ADDR_W = 2;
   localparam int unsigned MAX_ADDR_W = 3;

   function automatic int unsigned chan_count(input int unsigned aw);
      return 32'd1 << aw;
   endfunction

   function automatic bit width_ok(input int unsigned aw);
      return (aw >= MIN_ADDR_W) && (aw <= MAX_ADDR_W);
   endfunction
endpackage

// File: rtl/chan_hold_latch.sv
module chan_hold_latch #(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              en_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic              en_q
);
   // Reset wins over the strobe; write low makes the register follow.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         en_q   <= 1'b0;
      end else if (!wr) begin
         addr_q <= addr_in;
         en_q   <= en_in;
      end
   end

   AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ($stable(addr_q) && $stable(en_q)));  // R4
endmodule

// File: rtl/chan_hold_decode.sv
module chan_hold_decode #(
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned NCH = 1 << ADDR_W
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NCH-1:0]    sel
);
   for (genvar i = 0; i < NCH; i++) begin : g_chan
      assign sel[i] = en && (addr == ADDR_W'(i));
   end

   always_comb begin
      AST_ONE_HOT: assert ($onehot0(sel) || $isunknown(sel));  // R6
   end
endmodule

// File: rtl/chan_hold_sel.sv
module chan_hold_sel
   import chan_hold_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned NCH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en,
   output logic [NCH-1:0]    sw_on
);
   logic [ADDR_W-1:0] addr_q;
   logic              en_q;
   logic              init_q = 1'b0;

   if (!width_ok(ADDR_W)) begin : g_bad_width
      $error("chan_hold_sel: ADDR_W must be 2 or 3");
   end
   if (chan_count(ADDR_W) != NCH) begin : g_bad_count
      $error("chan_hold_sel: channel count mismatch");
   end

   chan_hold_latch #(.ADDR_W(ADDR_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr),
      .addr_in (addr),
      .en_in   (en),
      .addr_q  (addr_q),
      .en_q    (en_q)
   );

   chan_hold_decode #(.ADDR_W(ADDR_W)) u_dec (
      .en   (en_q),
      .addr (addr_q),
      .sel  (sw_on)
   );

   always_ff @(posedge clk) init_q <= 1'b1;

   AST_RESET_OFF: assert property (@(posedge clk) disable iff (!init_q)
      !rst_n |=> (sw_on == '0));  // R5
   AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !en) |=> (sw_on == '0));  // R3
   AST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && en) |=> (sw_on == (NCH'(1) << $past(addr))));  // R2
   AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> $stable(sw_on));  // R4
endmodule

// File: tb/test_chan_hold_sel.sv
module test_chan_hold_sel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0;
   logic [2:0] addr = '0;
   logic       en = 1'b0;
   logic [7:0] sw8;
   logic [3:0] sw4;

   typedef struct {
      logic [7:0] exp8;
      logic [3:0] exp4;
      string      tag;
   } item_t;

   item_t      sb[$];
   int         n_chk = 0;
   int         n_bad = 0;
   logic [2:0] m_addr = '0;
   logic       m_en = 1'b0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   chan_hold_sel #(.ADDR_W(3)) i_chan_hold_sel (
      .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .en(en), .sw_on(sw8));

   chan_hold_sel #(.ADDR_W(2)) i_chan_hold_sel_dual (
      .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr[1:0]), .en(en), .sw_on(sw4));

   // Driver: apply one cycle of inputs and queue the expected result.
   task automatic step(input logic r, input logic w, input logic [2:0] a,
                       input logic e, input string tag);
      item_t it;
      @(negedge clk);
      rst_n = r; wr = w; addr = a; en = e;
      if (!r) begin
         m_addr = '0; m_en = 1'b0;
      end else if (!w) begin
         m_addr = a; m_en = e;
      end
      it.exp8 = m_en ? (8'd1 << m_addr) : 8'd0;
      it.exp4 = m_en ? (4'd1 << m_addr[1:0]) : 4'd0;
      it.tag  = tag;
      sb.push_back(it);
   endtask

   // Monitor: compare shortly after each edge.
   always @(posedge clk) begin
      item_t it;
      #2;
      if (sb.size() > 0) begin
         it = sb.pop_front();
         n_chk += 2;
         if (sw8 !== it.exp8) begin
            n_bad++;
            $display("FAIL %s: 8-way sw_on=%b expected %b", it.tag, sw8, it.exp8);
         end
         if (sw4 !== it.exp4) begin
            n_bad++;
            $display("FAIL R7 (%s): 4-way sw_on=%b expected %b", it.tag, sw4, it.exp4);
         end
      end
   end

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      step(1'b0, 1'b0, 3'd0, 1'b0, "R5");
      step(1'b0, 1'b1, 3'd4, 1'b1, "R5");
      // Held after reset: stays off.
      step(1'b1, 1'b1, 3'd5, 1'b1, "R1");
      step(1'b1, 1'b1, 3'd2, 1'b1, "R1");
      // Transparent walk through every channel.
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'(i), 1'b1, "R2");
      step(1'b1, 1'b0, 3'd3, 1'b0, "R3");
      step(1'b1, 1'b0, 3'd7, 1'b0, "R3");
      // Capture channel 7 (address 6), then hold while inputs wander.
      step(1'b1, 1'b0, 3'd6, 1'b1, "R2");
      step(1'b1, 1'b1, 3'd1, 1'b1, "R4");
      step(1'b1, 1'b1, 3'd2, 1'b0, "R4");
      step(1'b1, 1'b1, 3'd7, 1'b1, "R4");
      // Leave the hold by write low.
      step(1'b1, 1'b0, 3'd1, 1'b1, "R8");
      step(1'b1, 1'b1, 3'd4, 1'b0, "R4");
      // Reset while holding.
      step(1'b0, 1'b1, 3'd5, 1'b1, "R5");
      step(1'b1, 1'b1, 3'd5, 1'b1, "R1");
      step(1'b1, 1'b0, 3'd5, 1'b1, "R8");
      step(1'b1, 1'b0, 3'd0, 1'b1, "R2");
      step(1'b1, 1'b0, 3'd0, 1'b1, "R6");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule